// File: doc/BRIEF.md
# Serial VFD Command Interface

This block is the host-facing command front end of a vacuum fluorescent display controller. A host sends 8-bit words over a three-wire link made of an active-low select, a serial clock and a data line. The block oversamples these three lines in its own system clock domain and assembles each word MSB first. The first word of every select frame picks the meaning of the frame. An address word loads a RAM address counter, and every later word in that frame becomes display data. An instruction word sets the scan and dimming controls, and every later word in that frame is void.

Display data goes out through a single-cycle RAM write port. The address counter steps by one after each data word. It returns to zero after the last address that the programmed scan duty uses. Addresses in areas that are unused or that do not exist are still counted, but they produce no write strobe.

The two instruction registers drive four settings: scan duty, pin pattern, grid dimming duty and display enable. A staged instruction takes effect only when select returns high. An active-low reset restores the default settings and never writes the RAM.

Top module: `vfd_serial_cmd`

## Requirements
- R1: Bits are taken on each rising serial clock edge while `csN` is low, MSB first, eight per word. Raising `csN` discards a partial word.
- R2: A first word whose bits 7:6 are 00 loads its bits 5:0 into the address counter.
- R3: Each later word in an address frame is written at the current address, and the address then increases by one.
- R4: The address returns to 0 after the limit that the scan duty sets. The `dutySel` encodings are 00=1/16 (limit 2Fh), 01=1/12 (limit 23h), 10=1/8 (limit 1Fh) and 11=1/4 (limit 0Fh). A loaded address above the limit also returns to 0 on its next step.
- R5: A first word with bit 7 = 1 is instruction 1. Its bits 5:4 go to `dutySel` and its bits 1:0 go to `pinPattern` (00 = pattern 1 through 11 = pattern 4).
- R6: A first word with bits 7:6 = 01 is instruction 2. Its bits 4:2 go to `dimSel` (000 = 2/16, then steps of 2/16 up to 110 = 14/16, and 111 = 15/16). Its bit 1 goes to `dispOn`.
- R7: Instruction settings change only at the rising edge of `csN`, never during the frame.
- R8: Words that follow an instruction word in the same frame cause no RAM write and no change of any setting.
- R9: While `rstN` is low, `dutySel`, `pinPattern` and `dimSel` are 0, `dispOn` is 0 and the address is 0. Reset never raises `ramWe`.
- R10: A data word whose address is above the duty limit, or at or above `RAM_DEPTH`, raises no `ramWe`, but it still advances the address.
- R11: Each new frame classifies its first word again, whatever the previous frame was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial frame select, active low |
| sClk | input | 1 | Serial bit clock |
| sData | input | 1 | Serial data, MSB first |
| ramWe | output | 1 | One-cycle display RAM write strobe |
| ramAddr | output | 6 | Display RAM write address |
| ramData | output | 8 | Display RAM write data |
| dutySel | output | 2 | Scan duty code |
| pinPattern | output | 2 | Pin pattern code |
| dimSel | output | 3 | Grid dimming duty code |
| dispOn | output | 1 | Display enable |

## Verification
The bench builds the block with its defaults: `RAM_DEPTH` = 47 and two synchroniser stages. With a depth of 47, address 2Fh is a valid step under the 1/16 duty but has no storage behind it. This puts the non-existent-address case and the 1/16 wrap within reach in the same short frame. Loaded addresses up to 3Fh, together with all four duty codes, let the random frames cover every wrap limit and the skip-but-advance path.

// File: rtl/vfd_cmd_pkg.sv
package vfd_cmd_pkg;
  localparam int WORD_BITS = 8;
  localparam int ADDR_BITS = 6;

  typedef struct packed {
    logic                 loadAddr;
    logic                 writeWord;
    logic                 stageI1;
    logic                 stageI2;
    logic                 commit;
    logic [WORD_BITS-1:0] word;
  } cmdStrobe_t;

  typedef enum logic [1:0] {
    FR_FIRST = 2'd0,
    FR_DATA  = 2'd1,
    FR_VOID  = 2'd2
  } frameMode_t;

  // Last address used by each scan duty code.
  function automatic logic [ADDR_BITS-1:0] wrapLimit(input logic [1:0] duty);
    case (duty)
      2'b00:   wrapLimit = 6'h2F;
      2'b01:   wrapLimit = 6'h23;
      2'b10:   wrapLimit = 6'h1F;
      default: wrapLimit = 6'h0F;
    endcase
  endfunction
endpackage

// File: rtl/vfd_cmd_ctrl.sv
module vfd_cmd_ctrl
  import vfd_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sClk,
  input  logic       sData,
  output cmdStrobe_t cmd
);
  localparam int BIT_W = $clog2(WORD_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  logic [SYNC_STAGES-1:0] csPipe, clkPipe, datPipe;
  logic csLast, sclkLast;
  logic csNow, sclkNow, datNow;
  logic frameActive, sclkRise, csRise, wordDone;
  logic [BIT_W-1:0] bitCnt;
  logic [WORD_BITS-2:0] shiftReg;
  logic [WORD_BITS-1:0] fullWord;
  frameMode_t mode;

  // Synchroniser chains, one stage per generate step.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          csPipe[0] <= 1'b1; clkPipe[0] <= 1'b0; datPipe[0] <= 1'b0;
        end else begin
          csPipe[0] <= csN; clkPipe[0] <= sClk; datPipe[0] <= sData;
        end
    end else begin : gTail
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          csPipe[g] <= 1'b1; clkPipe[g] <= 1'b0; datPipe[g] <= 1'b0;
        end else begin
          csPipe[g] <= csPipe[g-1]; clkPipe[g] <= clkPipe[g-1]; datPipe[g] <= datPipe[g-1];
        end
    end
  end

  assign csNow       = csPipe[SYNC_STAGES-1];
  assign sclkNow     = clkPipe[SYNC_STAGES-1];
  assign datNow      = datPipe[SYNC_STAGES-1];
  assign frameActive = !csNow;
  assign sclkRise    = sclkNow && !sclkLast;
  assign csRise      = csNow && !csLast;
  assign wordDone    = frameActive && sclkRise && (bitCnt == LAST_BIT);
  assign fullWord    = {shiftReg, datNow};

  always_comb begin
    cmd = '0;
    cmd.word   = fullWord;
    cmd.commit = csRise;
    if (wordDone) begin
      case (mode)
        FR_FIRST: begin
          if (fullWord[7:6] == 2'b00) cmd.loadAddr = 1'b1;
          else if (fullWord[7])       cmd.stageI1  = 1'b1;
          else                        cmd.stageI2  = 1'b1;
        end
        FR_DATA: cmd.writeWord = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLast   <= 1'b1;
      sclkLast <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
      mode     <= FR_FIRST;
    end else begin
      csLast   <= csNow;
      sclkLast <= sclkNow;
      if (!frameActive) begin
        bitCnt <= '0;
        mode   <= FR_FIRST;
      end else if (sclkRise) begin
        shiftReg <= fullWord[WORD_BITS-2:0];
        bitCnt   <= bitCnt + 1'b1;
        if (wordDone && mode == FR_FIRST)
          mode <= (fullWord[7:6] == 2'b00) ? FR_DATA : FR_VOID;
      end
    end
  end

  // R3/R11: at most one word strobe per cycle
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadAddr, cmd.writeWord, cmd.stageI1, cmd.stageI2}));
  // R1: no word completes while select is high
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    csNow |-> !(cmd.loadAddr || cmd.writeWord || cmd.stageI1 || cmd.stageI2));
  // R8: a void frame emits nothing
  p_void_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == FR_VOID) |-> !(cmd.writeWord || cmd.loadAddr || cmd.stageI1 || cmd.stageI2));
  // R11: a frame boundary returns to first-word classification
  p_frame_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    csNow |=> (mode == FR_FIRST));
endmodule

// File: rtl/vfd_cmd_dp.sv
module vfd_cmd_dp
  import vfd_cmd_pkg::*;
#(
  parameter int RAM_DEPTH = 47
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmdStrobe_t           cmd,
  output logic                 ramWe,
  output logic [ADDR_BITS-1:0] ramAddr,
  output logic [WORD_BITS-1:0] ramData,
  output logic [1:0]           dutySel,
  output logic [1:0]           pinPattern,
  output logic [2:0]           dimSel,
  output logic                 dispOn
);
  localparam logic [ADDR_BITS-1:0] LAST_ADDR = ADDR_BITS'(RAM_DEPTH - 1);

  logic [ADDR_BITS-1:0] addrCnt, limit;
  logic inRange, atLimit;
  logic pendI1, pendI2;
  logic [5:0] pendWord;

  assign limit   = wrapLimit(dutySel);
  assign inRange = (addrCnt <= limit) && (addrCnt <= LAST_ADDR);
  assign atLimit = (addrCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt    <= '0;
      ramWe      <= 1'b0;
      ramAddr    <= '0;
      ramData    <= '0;
      dutySel    <= 2'b00;
      pinPattern <= 2'b00;
      dimSel     <= 3'b000;
      dispOn     <= 1'b0;
      pendI1     <= 1'b0;
      pendI2     <= 1'b0;
      pendWord   <= '0;
    end else begin
      ramWe <= 1'b0;
      if (cmd.loadAddr) addrCnt <= cmd.word[ADDR_BITS-1:0];
      if (cmd.writeWord) begin
        ramWe   <= inRange;
        ramAddr <= addrCnt;
        ramData <= cmd.word;
        addrCnt <= atLimit ? '0 : addrCnt + 1'b1;
      end
      if (cmd.stageI1) begin
        pendI1   <= 1'b1;
        pendWord <= cmd.word[5:0];
      end
      if (cmd.stageI2) begin
        pendI2   <= 1'b1;
        pendWord <= cmd.word[5:0];
      end
      if (cmd.commit) begin
        if (pendI1) begin
          dutySel    <= pendWord[5:4];
          pinPattern <= pendWord[1:0];
        end
        if (pendI2) begin
          dimSel <= pendWord[4:2];
          dispOn <= pendWord[1];
        end
        pendI1 <= 1'b0;
        pendI2 <= 1'b0;
      end
    end
  end

  // R10: every strobed write lands inside the storage
  p_write_exists_r10: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr <= LAST_ADDR));
  // R4: every strobed write lies within the duty's address window
  p_write_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr <= wrapLimit(dutySel)));
  // R4: a step from the limit returns to zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writeWord && addrCnt == limit) |=> (addrCnt == '0));
  // R7: settings move only in the cycle after a frame end
  p_settings_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cmd.commit) |-> $stable({dutySel, pinPattern, dimSel, dispOn}));
endmodule

// File: rtl/vfd_serial_cmd.sv
module vfd_serial_cmd
  import vfd_cmd_pkg::*;
#(
  parameter int RAM_DEPTH   = 47,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sClk,
  input  logic       sData,
  output logic       ramWe,
  output logic [5:0] ramAddr,
  output logic [7:0] ramData,
  output logic [1:0] dutySel,
  output logic [1:0] pinPattern,
  output logic [2:0] dimSel,
  output logic       dispOn
);
  cmdStrobe_t cmd;

  vfd_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sClk(sClk), .sData(sData), .cmd(cmd)
  );

  vfd_cmd_dp #(.RAM_DEPTH(RAM_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .dutySel(dutySel), .pinPattern(pinPattern), .dimSel(dimSel), .dispOn(dispOn)
  );
endmodule

// File: tb/vfd_serial_cmd_test.sv
module vfd_serial_cmd_test;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 40;
  localparam int GAP        = 200;
  localparam int DEPTH      = 47;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sClk = 1'b0, sData = 1'b0;
  logic ramWe; logic [5:0] ramAddr; logic [7:0] ramData;
  logic [1:0] dutySel, pinPattern; logic [2:0] dimSel; logic dispOn;

  vfd_serial_cmd uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, wrTotal = 0, expWr = 0;
  bit finished = 0;
  logic [7:0] gotRam [64];
  logic [7:0] expRam [64];
  logic [7:0] frameBuf [16];
  logic [1:0] mDuty, mPat; logic [2:0] mDim; logic mDisp; logic [5:0] mAddr;

  always @(posedge clk) if (rstN && ramWe) begin
    gotRam[ramAddr] <= ramData;
    wrTotal <= wrTotal + 1;
  end

  function automatic logic [5:0] limOf(input logic [1:0] d);
    case (d) 2'b00: return 6'h2F; 2'b01: return 6'h23; 2'b10: return 6'h1F; default: return 6'h0F; endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic modelReset();
    mDuty = 0; mPat = 0; mDim = 0; mDisp = 0; mAddr = 0;
  endtask

  task automatic modelFrame(input int n);
    logic [7:0] w0 = frameBuf[0];
    if (n == 0) return;
    if (w0[7:6] == 2'b00) begin
      mAddr = w0[5:0];
      for (int i = 1; i < n; i++) begin
        if (mAddr <= limOf(mDuty) && mAddr < DEPTH) begin expRam[mAddr] = frameBuf[i]; expWr++; end
        mAddr = (mAddr >= limOf(mDuty)) ? 6'd0 : mAddr + 6'd1;
      end
    end else if (w0[7]) begin mDuty = w0[5:4]; mPat = w0[1:0]; end
    else begin mDim = w0[4:2]; mDisp = w0[1]; end
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sData = b[i]; #(SCK_HALF); sClk = 1'b1; #(SCK_HALF); sClk = 1'b0;
    end
  endtask

  task automatic runFrame(input int n);
    csN = 1'b0; #(SCK_HALF);
    for (int i = 0; i < n; i++) sendByte(frameBuf[i]);
    #(SCK_HALF); csN = 1'b1; #(GAP);
    modelFrame(n);
  endtask

  task automatic checkAll(input string req);
    int bad = 0;
    for (int a = 0; a < 64; a++) if (gotRam[a] !== expRam[a]) bad++;
    check(bad == 0, {req, " ram"}, bad, 0);
    check(wrTotal == expWr, {req, " writes"}, wrTotal, expWr);
    check({dutySel, pinPattern, dimSel, dispOn} === {mDuty, mPat, mDim, mDisp}, {req, " settings"},
          int'({dutySel, pinPattern, dimSel, dispOn}), int'({mDuty, mPat, mDim, mDisp}));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0427);
    for (int a = 0; a < 64; a++) begin gotRam[a] = 8'h00; expRam[a] = 8'h00; end
    modelReset();
    #(5*CLK_PERIOD);
    // R9: defaults while and after reset
    check({dutySel, pinPattern, dimSel, dispOn, ramWe} === 9'b0, "R9 reset outputs",
          int'({dutySel, pinPattern, dimSel, dispOn, ramWe}), 0);
    rstN = 1'b1; #(5*CLK_PERIOD);
    checkAll("R9 after reset");

    // R5 + R7: instruction 1 held until select rises
    csN = 1'b0; #(SCK_HALF); sendByte(8'hA3); #(GAP);
    check(dutySel == 2'b00 && pinPattern == 2'b00, "R7 held mid-frame", int'({dutySel, pinPattern}), 0);
    csN = 1'b1; #(GAP);
    frameBuf[0] = 8'hA3; modelFrame(1);
    check(dutySel == 2'b10 && pinPattern == 2'b11, "R5 instr1 fields", int'({dutySel, pinPattern}), 4'b1011);

    // R6: instruction 2
    frameBuf[0] = 8'h56; runFrame(1);
    check(dimSel == 3'b101 && dispOn, "R6 instr2 fields", int'({dimSel, dispOn}), 4'b1011);

    // R2/R3/R4: 1/8 duty wrap at 1Fh
    frameBuf[0] = 8'h1E; frameBuf[1] = 8'h11; frameBuf[2] = 8'h22; frameBuf[3] = 8'h33; frameBuf[4] = 8'h44;
    runFrame(5);
    check(gotRam[6'h1F] == 8'h22 && gotRam[0] == 8'h33 && gotRam[1] == 8'h44, "R4 wrap 1/8",
          int'(gotRam[0]), 8'h33);
    checkAll("R3 data frame");

    // R8: words after an instruction are void
    frameBuf[0] = 8'h80; frameBuf[1] = 8'h05; frameBuf[2] = 8'h5E; frameBuf[3] = 8'hFF;
    runFrame(4);
    checkAll("R8 void frame");

    // R10: 1/16 duty, 2Fh has no storage, then wrap
    frameBuf[0] = 8'h2E; frameBuf[1] = 8'hA1; frameBuf[2] = 8'hA2; frameBuf[3] = 8'hA3;
    runFrame(4);
    check(gotRam[0] == 8'hA3 && gotRam[6'h2E] == 8'hA1, "R10 skip 2Fh", int'(gotRam[0]), 8'hA3);
    frameBuf[0] = 8'h3F; frameBuf[1] = 8'hB1; frameBuf[2] = 8'hB2;
    runFrame(3);
    checkAll("R10 beyond limit");

    // R1/R11: partial word dropped, next frame reclassifies
    csN = 1'b0; #(SCK_HALF);
    for (int i = 0; i < 3; i++) begin sData = 1'b1; #(SCK_HALF); sClk = 1'b1; #(SCK_HALF); sClk = 1'b0; end
    csN = 1'b1; #(GAP);
    frameBuf[0] = 8'h05; frameBuf[1] = 8'hAA; runFrame(2);
    check(gotRam[5] == 8'hAA, "R1 partial discard", int'(gotRam[5]), 8'hAA);
    checkAll("R11 reclassify");

    // R4: 1/12 wrap at 23h, then 1/4 from an out-of-window address
    frameBuf[0] = 8'h90; runFrame(1);
    frameBuf[0] = 8'h22; frameBuf[1] = 8'hC1; frameBuf[2] = 8'hC2; frameBuf[3] = 8'hC3; runFrame(4);
    checkAll("R4 wrap 1/12");
    frameBuf[0] = 8'hB0; runFrame(1);
    frameBuf[0] = 8'h10; frameBuf[1] = 8'hD1; frameBuf[2] = 8'hD2; runFrame(3);
    checkAll("R4 wrap 1/4");

    // Random frames: R2 R3 R4 R5 R6 R8 R10 R11
    for (int f = 0; f < 40; f++) begin
      int n, kind;
      n = 1 + int'($urandom % 6);
      kind = int'($urandom % 4);
      frameBuf[0] = 8'($urandom);
      if (kind < 2) frameBuf[0][7:6] = 2'b00;
      for (int i = 1; i < n; i++) frameBuf[i] = 8'($urandom);
      runFrame(n);
      checkAll("R3 random frame");
    end

    // R9: reset restores settings, RAM untouched
    frameBuf[0] = 8'hF3; runFrame(1);
    frameBuf[0] = 8'h5E; runFrame(1);
    rstN = 1'b0; #(5*CLK_PERIOD);
    modelReset();
    check({dutySel, pinPattern, dimSel, dispOn} === 8'b0, "R9 mid-run reset",
          int'({dutySel, pinPattern, dimSel, dispOn}), 0);
    rstN = 1'b1; #(5*CLK_PERIOD);
    checkAll("R9 ram kept");
    frameBuf[0] = 8'h00; frameBuf[1] = 8'h77; runFrame(2);
    checkAll("R9 address usable after reset");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule